// File: doc/BRIEF.md
# Block Write-Protection Gate

This block sits in front of the programming path of an 11-bit-addressed byte store. Each write byte that the bus side has already decoded is offered to it with its address. The block decides whether that byte may be programmed. The decision depends on four things: a two-bit upper-block selector pin pair, a protect-arm pin, an optional hardware write-inhibit pin, and the contents of the control byte held at the topmost address. The byte then leaves on a result stream together with an allow flag. A byte that is refused still produces a result, because the bus has already acknowledged it. The downstream programmer discards any result whose allow flag is low.

A write transaction is bracketed by `txn_open` and `txn_close` pulses. On `txn_open` the block captures the selector pins, the arm pin, the inhibit pin and the control byte. It then uses that captured copy for every byte until `txn_close`, so the protected range cannot shift partway through a burst. Write requests arrive over a valid/ready stream. A request is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low outside a transaction, and it is also low while the single result register is full and the consumer holds `res_ready` low. A result is consumed on an edge where `res_valid` and `res_ready` are both high. While `res_ready` stays low, the pending result holds still.

Top module: `wp_guard`

## Requirements
- R1: The control byte carries the arm flag at bit 2 and a 16-byte offset in bits 7:4. When protection is armed, the first protected address is 400h + sel*100h + offset*10h, where sel is the value on `sel_blk`. Every address from there up to 7FEh is refused, and every address below it is allowed.
- R2: Protection is armed only when `arm_pin` is high and the control byte's bit 2 is set. If either is low, every address is allowed (unless R4 applies).
- R3: A write to the control location 7FFh is always allowed, whether or not protection is armed, unless the hardware inhibit of R4 is active.
- R4: With HAS_WC=1, `wc_pin` high refuses every address, 7FFh included. `wc_pin` low leaves the decision to R1 to R3. A pin that is left undriven must therefore be tied low.
- R5: Addresses 000h to 3FFh are never refused by the range logic, for any selector, offset or flag value.
- R6: The selector, arm pin, inhibit pin and control byte are captured on `txn_open`. Changes to them before `txn_close` have no effect on results.
- R7: Every accepted request yields exactly one result, in order. The result repeats the request's address and data and carries `res_allow`. Refused bytes also yield a result, with `res_allow` low.
- R8: While `res_valid` is high and `res_ready` is low, the result holds its value. `wr_ready` is low while no transaction is open.
- R9: After reset no transaction is open, `res_valid` is low and `wr_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_blk | input | 2 | Upper block that holds the protection start |
| arm_pin | input | 1 | Protect-arm pin |
| wc_pin | input | 1 | Hardware write inhibit, high = refuse all |
| ctrl_byte | input | 8 | Current content of location 7FFh |
| txn_open | input | 1 | Write transaction begins; captures configuration |
| txn_close | input | 1 | Write transaction ends |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted when high with valid |
| wr_addr | input | 11 | Byte address of the write |
| wr_data | input | 8 | Byte value of the write |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes result |
| res_addr | output | 11 | Address of the result |
| res_data | output | 8 | Data of the result |
| res_allow | output | 1 | High = program the byte, low = discard |

## Verification
For every selector value and for offsets 0, 7 and 15, the bench probes the addresses one below the start, at the start, and one past it. These separate an off-by-one compare and a wrong weighting of the selector or offset bits. Probes at 3FFh, 400h, 7FEh and 7FFh confirm that the lower half stays open and that the control location is exempt. The same addresses are replayed with only the arm pin set, with only the flag set, and with the inhibit pin high, which shows that arming needs both inputs and that the inhibit overrides everything. After each open, the bench drives inverted values onto every configuration pin, so any leak of live pins into the decision shows up. A periodically stalled consumer exercises the hold behaviour of the result stream.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int unsigned WP_ADDR_W = 11;
  localparam int unsigned WP_DATA_W = 8;
  localparam int unsigned WP_SEL_W  = 2;
  localparam int unsigned WP_GRAN_W = 4;
  localparam int unsigned WP_FLAG_BIT = 2;
  localparam int unsigned WP_OFS_LSB  = 4;

  typedef enum logic {TXN_IDLE = 1'b0, TXN_OPEN = 1'b1} txn_state_e;
endpackage

// File: rtl/wp_cfg_hold.sv
module wp_cfg_hold #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txn_open,
  input  logic             txn_close,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             arm_in,
  input  logic             wc_in,
  input  logic [CFG_W-1:0] cfg_in,
  output logic             open_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             arm_q,
  output logic             wc_q,
  output logic [CFG_W-1:0] cfg_q
);
  import wp_pkg::*;

  txn_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TXN_IDLE;
      sel_q   <= '0;
      arm_q   <= 1'b0;
      wc_q    <= 1'b0;
      cfg_q   <= '0;
    end else if (txn_open) begin
      state_q <= TXN_OPEN;
      sel_q   <= sel_in;
      arm_q   <= arm_in;
      wc_q    <= wc_in;
      cfg_q   <= cfg_in;
    end else if (txn_close) begin
      state_q <= TXN_IDLE;
    end
  end

  assign open_q = (state_q == TXN_OPEN);

  // R6: captured configuration is frozen between open and close
  assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !txn_open) |=> ($stable(sel_q) && $stable(arm_q) && $stable(wc_q) && $stable(cfg_q)));
endmodule

// File: rtl/wp_range_cmp.sv
module wp_range_cmp #(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned GRAN_W   = 4,
  parameter int unsigned CFG_W    = 8,
  parameter int unsigned FLAG_BIT = 2,
  parameter int unsigned OFS_LSB  = 4,
  parameter bit          HAS_WC   = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEL_W-1:0]  sel,
  input  logic              arm,
  input  logic              wc,
  input  logic [CFG_W-1:0]  cfg,
  output logic              hw_inhibit,
  output logic              allow
);
  localparam int unsigned BLK_W = ADDR_W - 1 - SEL_W;
  localparam int unsigned OFS_W = BLK_W - GRAN_W;

  logic [OFS_W-1:0]  offset;
  logic [ADDR_W-1:0] start_addr;
  logic              armed;
  logic              is_ctrl;
  logic              in_range;

  assign offset     = cfg[OFS_LSB +: OFS_W];
  assign start_addr = {1'b1, sel, offset, {GRAN_W{1'b0}}};
  assign armed      = arm & cfg[FLAG_BIT];
  assign is_ctrl    = &addr;
  assign in_range   = (addr >= start_addr);

  generate
    if (HAS_WC) begin : g_wc
      assign hw_inhibit = wc;
    end else begin : g_no_wc
      logic unused_wc;
      assign unused_wc  = wc;
      assign hw_inhibit = 1'b0;
    end
  endgenerate

  always_comb begin
    if (hw_inhibit)                       allow = 1'b0;
    else if (armed && in_range && !is_ctrl) allow = 1'b0;
    else                                  allow = 1'b1;
  end
endmodule

// File: rtl/wp_resp_stage.sv
module wp_resp_stage #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_allow,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_allow
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
      out_allow <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr  <= in_addr;
        out_data  <= in_data;
        out_allow <= in_allow;
      end
    end
  end

  // R8: a stalled result stays put
  assert_res_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data) && $stable(out_allow)));
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int unsigned ADDR_W   = wp_pkg::WP_ADDR_W,
  parameter int unsigned DATA_W   = wp_pkg::WP_DATA_W,
  parameter int unsigned SEL_W    = wp_pkg::WP_SEL_W,
  parameter int unsigned GRAN_W   = wp_pkg::WP_GRAN_W,
  parameter int unsigned FLAG_BIT = wp_pkg::WP_FLAG_BIT,
  parameter int unsigned OFS_LSB  = wp_pkg::WP_OFS_LSB,
  parameter bit          HAS_WC   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel_blk,
  input  logic              arm_pin,
  input  logic              wc_pin,
  input  logic [DATA_W-1:0] ctrl_byte,
  input  logic              txn_open,
  input  logic              txn_close,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_addr,
  output logic [DATA_W-1:0] res_data,
  output logic              res_allow
);
  logic              open_q;
  logic [SEL_W-1:0]  sel_q;
  logic              arm_q;
  logic              wc_q;
  logic [DATA_W-1:0] cfg_q;
  logic              hw_inh;
  logic              cmp_allow;
  logic              stage_ready;
  logic              take;

  wp_cfg_hold #(.SEL_W(SEL_W), .CFG_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .txn_open(txn_open), .txn_close(txn_close),
    .sel_in(sel_blk), .arm_in(arm_pin), .wc_in(wc_pin), .cfg_in(ctrl_byte),
    .open_q(open_q), .sel_q(sel_q), .arm_q(arm_q), .wc_q(wc_q), .cfg_q(cfg_q)
  );

  wp_range_cmp #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .GRAN_W(GRAN_W), .CFG_W(DATA_W),
    .FLAG_BIT(FLAG_BIT), .OFS_LSB(OFS_LSB), .HAS_WC(HAS_WC)
  ) u_cmp (
    .addr(wr_addr), .sel(sel_q), .arm(arm_q), .wc(wc_q), .cfg(cfg_q),
    .hw_inhibit(hw_inh), .allow(cmp_allow)
  );

  wp_resp_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_res (
    .clk(clk), .rst_n(rst_n),
    .in_valid(wr_valid && open_q), .in_ready(stage_ready),
    .in_addr(wr_addr), .in_data(wr_data), .in_allow(cmp_allow),
    .out_valid(res_valid), .out_ready(res_ready),
    .out_addr(res_addr), .out_data(res_data), .out_allow(res_allow)
  );

  assign wr_ready = open_q && stage_ready;
  assign take     = wr_valid && wr_ready;

  // R8: no request is taken while idle
  assert_idle_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |-> !wr_ready);

  // R3: control location passes unless hardware inhibit is on
  assert_ctrl_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (&wr_addr) && !hw_inh) |-> cmp_allow);

  // R5: lower half is never refused by the range logic
  assert_low_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_addr[ADDR_W-1] && !hw_inh) |-> cmp_allow);

  // R2: with the arm pin captured low nothing but the inhibit refuses
  assert_disarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !arm_q && !hw_inh) |-> cmp_allow);

  // R7: an accepted request shows up as a result on the next cycle
  assert_take_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (res_valid && res_addr == $past(wr_addr)));

  generate
    if (HAS_WC) begin : g_wc_chk
      // R4: inhibit refuses everything
      assert_inhibit_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && wc_q) |-> !cmp_allow);
    end
  endgenerate
endmodule

// File: tb/wp_guard_test.sv
module wp_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel_blk = '0;
  logic        arm_pin = 1'b0;
  logic        wc_pin = 1'b0;
  logic [7:0]  ctrl_byte = '0;
  logic        txn_open = 1'b0;
  logic        txn_close = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [10:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        res_valid;
  logic        res_ready;
  logic [10:0] res_addr;
  logic [7:0]  res_data;
  logic        res_allow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [19:0] exp_q[$];
  logic [1:0]  m_blk;
  logic        m_arm, m_flag, m_wc;
  logic [3:0]  m_nib;
  logic [2:0]  rdy_cnt = '0;

  always #5 clk = ~clk;

  wp_guard uut (
    .clk(clk), .rst_n(rst_n), .sel_blk(sel_blk), .arm_pin(arm_pin), .wc_pin(wc_pin),
    .ctrl_byte(ctrl_byte), .txn_open(txn_open), .txn_close(txn_close),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_addr(res_addr),
    .res_data(res_data), .res_allow(res_allow)
  );

  always @(posedge clk) rdy_cnt <= rdy_cnt + 3'd1;
  assign res_ready = (rdy_cnt[1:0] != 2'd3);

  function automatic logic model_allow(input logic [10:0] a);
    logic [11:0] start;
    start = 12'h400 + 12'(m_blk) * 12'h100 + 12'(m_nib) * 12'h10;
    if (m_wc) return 1'b0;                             // R4
    if (a == 11'h7FF) return 1'b1;                     // R3
    if (m_arm && m_flag && {1'b0, a} >= start) return 1'b0; // R1 R2
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pop and compare on handshake, watch stalls
  logic        stall_prev = 1'b0;
  logic [19:0] prev_res;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev)
        check(res_valid && {res_allow, res_data, res_addr} == prev_res, "R8",
              "stalled result changed", int'({res_allow, res_data, res_addr}), int'(prev_res));
      if (res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected result", int'(res_addr), 0);
        end else begin
          logic [19:0] e;
          e = exp_q.pop_front();
          check(e[10:0] == res_addr && e[18:11] == res_data, "R7", "address/data",
                int'({res_data, res_addr}), int'(e[18:0]));
          check(e[19] == res_allow,
                (e[10:0] == 11'h7FF) ? "R3" : (e[10] ? "R1" : "R5"),
                $sformatf("allow at %0h", e[10:0]), int'(res_allow), int'(e[19]));
        end
      end
      stall_prev = res_valid && !res_ready;
      prev_res   = {res_allow, res_data, res_addr};
    end
  end

  task automatic send(input logic [10:0] a);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = a[7:0] ^ 8'h5A;
    while (!wr_ready) @(negedge clk);
    exp_q.push_back({model_allow(a), a[7:0] ^ 8'h5A, a});
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic open_txn(input logic [1:0] blk, input logic arm, input logic flag,
                          input logic [3:0] nib, input logic wc);
    m_blk = blk; m_arm = arm; m_flag = flag; m_nib = nib; m_wc = wc;
    sel_blk   = blk;
    arm_pin   = arm;
    wc_pin    = wc;
    ctrl_byte = {nib, 1'b1, flag, 2'b10};
    txn_open  = 1'b1;
    @(negedge clk);
    txn_open  = 1'b0;
    // R6: scramble live pins; results must follow the captured copy
    sel_blk   = ~blk;
    arm_pin   = ~arm;
    wc_pin    = ~wc;
    ctrl_byte = ~ctrl_byte;
  endtask

  task automatic close_txn();
    while (exp_q.size() != 0) @(negedge clk);
    txn_close = 1'b1;
    @(negedge clk);
    txn_close = 1'b0;
    check(wr_ready == 1'b0, "R8", "ready while idle", int'(wr_ready), 0);
  endtask

  task automatic probe_set(input logic [10:0] st);
    send(st - 11'd1);
    send(st);
    send(st + 11'd1);
    send(11'h3FF);
    send(11'h400);
    send(11'h7FE);
    send(11'h7FF);
    send(11'h000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!res_valid && !wr_ready, "R9", "reset state", int'({res_valid, wr_ready}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!wr_ready, "R9", "idle after reset", int'(wr_ready), 0);

    // R1 R5 R3: armed, every selector, several offsets
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 3; k++) begin
        logic [3:0] nib;
        nib = (k == 0) ? 4'd0 : (k == 1) ? 4'd7 : 4'd15;
        open_txn(2'(b), 1'b1, 1'b1, nib, 1'b0);
        probe_set(11'h400 + 11'(b) * 11'h100 + 11'(nib) * 11'h10);
        close_txn();
      end
    end

    // R2: arm pin only, flag only
    open_txn(2'd1, 1'b1, 1'b0, 4'd3, 1'b0);
    probe_set(11'h530);
    close_txn();
    open_txn(2'd2, 1'b0, 1'b1, 4'd3, 1'b0);
    probe_set(11'h630);
    close_txn();

    // R4: hardware inhibit refuses all, including 7FFh
    open_txn(2'd0, 1'b0, 1'b0, 4'd0, 1'b1);
    probe_set(11'h400);
    close_txn();

    // R6: live pins scrambled after open, protection stays at captured 0x700
    open_txn(2'd3, 1'b1, 1'b1, 4'd0, 1'b0);
    sel_blk = 2'd0; ctrl_byte = 8'h04; arm_pin = 1'b1;
    probe_set(11'h700);
    close_txn();

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7", "results outstanding", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule